// File: doc/BRIEF.md
# Burst-of-Two Dual-Port DDR SRAM Model

This block is a synthesizable functional model of a synchronous SRAM with separate read and write data paths. Each transaction moves a burst of two words. Both ports run from one fast clock `clk` at twice the command rate. The input `khalf` marks which half of the slower command clock the next `clk` edge represents: 0 for the rising half and 1 for the falling half. The bench or the surrounding logic toggles `khalf` on every `clk` edge.

The array is organised as pairs of words. An address selects a pair. Beat 0 of a burst maps to the even word of that pair and beat 1 maps to the odd word. Writes carry an active-low enable for each 9-bit lane and for each beat. A read returns its two beats a fixed number of half-cycles after the command. The `rvalid` flag stands in for a driven bus; when it is low, `rdata` is zero. A read that targets a pair whose write is still in flight receives the new data through a forwarding path.

Top module: `sq_b2_sram`

## Requirements
- R1: After reset, `rvalid` is 0, `rdata` is 0, the read pipeline is empty and no write is pending.
- R2: When `rd_n` is 0 on an edge with `khalf`=0 (edge t), `rdata` shows the even word of pair `rd_addr` with `rvalid`=1 after edge t+4. It shows the odd word with `rvalid`=1 after edge t+5.
- R3: When `rd_n` is 1 on a `khalf`=0 edge, the two output slots that belong to that command show `rvalid`=0 and `rdata`=0, whatever `rd_addr` holds.
- R4: `rd_n` and `rd_addr` are ignored on edges with `khalf`=1.
- R5: When `wr_n` is 0 on a `khalf`=0 edge (edge t), `wr_addr` is captured. `wdata` and `bw_n` at edge t+1 form beat 0, which goes to the even word. At edge t+2 they form beat 1, which goes to the odd word. Both words are written at edge t+2.
- R6: `bw_n[i]` covers data bits 9i+8..9i. A value of 0 writes that lane and a value of 1 keeps the old lane content. This is evaluated separately for each beat, so all four beat-0/beat-1 combinations work.
- R7: When `wr_n` is 1 on a `khalf`=0 edge, no word changes, whatever the address, data and enables hold.
- R8: A read issued on the same `khalf`=0 edge as a write to the same pair returns the merged new data.
- R9: Reads issued on consecutive `khalf`=0 edges give a gap-free stream of beats, each beat with its own data.
- R10: `wr_n` and `wr_addr` are ignored on edges with `khalf`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per command cycle |
| rst | input | 1 | Synchronous active-high reset |
| khalf | input | 1 | Half-cycle marker for the next edge (0 = rising half) |
| rd_n | input | 1 | Active-low read select |
| rd_addr | input | AW | Read pair address |
| wr_n | input | 1 | Active-low write select |
| wr_addr | input | AW | Write pair address |
| bw_n | input | LANES | Active-low lane write enables for the current beat |
| wdata | input | 9*LANES | Write beat data |
| rdata | output | 9*LANES | Read beat data, zero when idle |
| rvalid | output | 1 | Read beat valid |

## Verification
On every cycle, the assertions check the following:
- Each accepted read produces exactly two valid slots at the fixed offsets.
- `rdata` is zero whenever `rvalid` is low.
- Commands seen in the falling half never produce output or a commit.
- A commit always traces back to a write select two edges earlier.

The data content needs the bench's reference model and its scenarios. This covers lane-masked merges in all four beat combinations, deselected writes that leave memory untouched, and forwarding of an in-flight write into a read.

// File: rtl/sqb2_pkg.sv
package sqb2_pkg;
    localparam int LANE_W = 9;
    localparam logic PH_RISE = 1'b0;
    typedef enum logic {BEAT_EVEN = 1'b0, BEAT_ODD = 1'b1} beat_e;

    function automatic int lane_lo(input int lane);
        return lane * LANE_W;
    endfunction
endpackage

// File: rtl/sq_wr_capture.sv
module sq_wr_capture
    import sqb2_pkg::*;
#(
    parameter int LANES = 2,
    parameter int AW    = 4,
    localparam int W    = LANES * LANE_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         khalf,
    input  logic                         wr_n,
    input  logic [AW-1:0]                wr_addr,
    input  logic [LANES-1:0]             bw_n,
    input  logic [W-1:0]                 wdata,
    output logic                         commit,
    output logic [AW-1:0]                c_addr,
    output logic [1:0][W-1:0]            c_data,
    output logic [1:0][LANES-1:0]        c_bwn
);
    logic             pend;
    logic [AW-1:0]    addr_q;
    logic [W-1:0]     d0_q;
    logic [LANES-1:0] bw0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            addr_q <= '0;
            d0_q   <= '0;
            bw0_q  <= '1;
        end else if (khalf == PH_RISE) begin
            pend   <= !wr_n;
            addr_q <= wr_addr;
        end else if (pend) begin
            d0_q  <= wdata;
            bw0_q <= bw_n;
        end
    end

    // Beat 1 arrives on the rising-half edge that also commits the burst.
    assign commit            = pend && (khalf == PH_RISE);
    assign c_addr            = addr_q;
    assign c_data[BEAT_EVEN] = d0_q;
    assign c_bwn[BEAT_EVEN]  = bw0_q;
    assign c_data[BEAT_ODD]  = wdata;
    assign c_bwn[BEAT_ODD]   = bw_n;
endmodule

// File: rtl/sq_pair_array.sv
module sq_pair_array
    import sqb2_pkg::*;
#(
    parameter int LANES = 2,
    parameter int PAIRS = 16,
    localparam int AW   = $clog2(PAIRS),
    localparam int W    = LANES * LANE_W
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [1:0][W-1:0]     wd,
    input  logic [1:0][LANES-1:0] wbn,
    input  logic [AW-1:0]         raddr,
    output logic [1:0][W-1:0]     rd
);
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [W-1:0] bank [PAIRS];

        always_ff @(posedge clk) begin
            if (we) begin
                for (int l = 0; l < LANES; l++) begin
                    if (!wbn[b][l])
                        bank[waddr][lane_lo(l) +: LANE_W] <= wd[b][lane_lo(l) +: LANE_W];
                end
            end
        end

        assign rd[b] = bank[raddr];
    end
endmodule

// File: rtl/sq_rd_pipe.sv
module sq_rd_pipe
    import sqb2_pkg::*;
#(
    parameter int LANES = 2,
    parameter int AW    = 4,
    localparam int W    = LANES * LANE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  khalf,
    input  logic                  rd_n,
    input  logic [AW-1:0]         rd_addr,
    output logic [AW-1:0]         look_addr,
    input  logic [1:0][W-1:0]     arr_rd,
    input  logic                  commit,
    input  logic [AW-1:0]         c_addr,
    input  logic [1:0][W-1:0]     c_data,
    input  logic [1:0][LANES-1:0] c_bwn,
    output logic [W-1:0]          rdata,
    output logic                  rvalid
);
    logic             a_v, b_v, h_v;
    logic [AW-1:0]    a_addr;
    logic [1:0][W-1:0] b_data;
    logic [W-1:0]     h_data;
    logic [1:0][W-1:0] merged;
    logic             hit;

    assign look_addr = a_addr;
    assign hit       = commit && (c_addr == a_addr);

    // Forward lanes of the burst being committed on this very edge.
    always_comb begin
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < LANES; l++) begin
                merged[b][lane_lo(l) +: LANE_W] = (hit && !c_bwn[b][l])
                    ? c_data[b][lane_lo(l) +: LANE_W]
                    : arr_rd[b][lane_lo(l) +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_v    <= 1'b0;
            b_v    <= 1'b0;
            h_v    <= 1'b0;
            a_addr <= '0;
            b_data <= '0;
            h_data <= '0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (khalf == PH_RISE) begin
            a_v    <= !rd_n;
            a_addr <= rd_addr;
            b_v    <= a_v;
            b_data <= merged;
            h_v    <= b_v;
            h_data <= b_data[BEAT_ODD];
            rvalid <= b_v;
            rdata  <= b_v ? b_data[BEAT_EVEN] : '0;
        end else begin
            rvalid <= h_v;
            rdata  <= h_v ? h_data : '0;
        end
    end
endmodule

// File: rtl/sq_b2_sram.sv
module sq_b2_sram
    import sqb2_pkg::*;
#(
    parameter int LANES = 2,
    parameter int PAIRS = 16,
    localparam int AW   = $clog2(PAIRS),
    localparam int W    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             khalf,
    input  logic             rd_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_n,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] bw_n,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic             rvalid
);
    logic                  wr_commit;
    logic [AW-1:0]         c_addr;
    logic [1:0][W-1:0]     c_data;
    logic [1:0][LANES-1:0] c_bwn;
    logic [AW-1:0]         look_addr;
    logic [1:0][W-1:0]     arr_rd;

    sq_wr_capture #(.LANES(LANES), .AW(AW)) u_wr (
        .clk(clk), .rst(rst), .khalf(khalf), .wr_n(wr_n), .wr_addr(wr_addr),
        .bw_n(bw_n), .wdata(wdata), .commit(wr_commit), .c_addr(c_addr),
        .c_data(c_data), .c_bwn(c_bwn)
    );

    sq_pair_array #(.LANES(LANES), .PAIRS(PAIRS)) u_arr (
        .clk(clk), .we(wr_commit), .waddr(c_addr), .wd(c_data), .wbn(c_bwn),
        .raddr(look_addr), .rd(arr_rd)
    );

    sq_rd_pipe #(.LANES(LANES), .AW(AW)) u_rd (
        .clk(clk), .rst(rst), .khalf(khalf), .rd_n(rd_n), .rd_addr(rd_addr),
        .look_addr(look_addr), .arr_rd(arr_rd), .commit(wr_commit),
        .c_addr(c_addr), .c_data(c_data), .c_bwn(c_bwn),
        .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: rtl/sq_b2_sram_chk.sv
module sq_b2_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          khalf,
    input logic          rd_n,
    input logic          wr_n,
    input logic          rvalid,
    input logic [DW-1:0] rdata,
    input logic          commit
);
    assert_q0_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (!khalf && !rd_n) |-> ##5 rvalid);
    assert_q1_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (!khalf && !rd_n) |-> ##6 rvalid);
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));
    assert_no_orphan_beat_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ($past(!khalf && !rd_n, 5) || $past(!khalf && !rd_n, 6)));
    assert_commit_origin_R5: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(!khalf && !wr_n, 2));
    assert_no_commit_on_deselect_R7: assert property (@(posedge clk) disable iff (rst)
        (!khalf && wr_n) |-> ##2 !commit);
endmodule

bind sq_b2_sram sq_b2_sram_chk #(.DW(LANES * 9)) u_chk (
    .clk(clk), .rst(rst), .khalf(khalf), .rd_n(rd_n), .wr_n(wr_n),
    .rvalid(rvalid), .rdata(rdata), .commit(wr_commit)
);

// File: tb/tb_sq_b2_sram.sv
`timescale 1ns/1ps
module tb_sq_b2_sram;
    localparam int LANES = 2;
    localparam int PAIRS = 16;
    localparam int AW    = $clog2(PAIRS);
    localparam int W     = LANES * 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic khalf = 1'b0;
    logic rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [LANES-1:0] bw_n = '1;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic rvalid;

    always #2.5 clk = ~clk;

    sq_b2_sram #(.LANES(LANES), .PAIRS(PAIRS)) dut (
        .clk(clk), .rst(rst), .khalf(khalf), .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .bw_n(bw_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    int checks = 0, bad = 0, cyc = 0;
    string cur_req = "R1";
    logic [W-1:0] mem [2*PAIRS];
    logic exp_v [8];
    logic [W-1:0] exp_d [8];
    logic m_wpend = 0, m_rpend = 0;
    logic [AW-1:0] m_wa, m_ra;
    logic [W-1:0] m_d0;
    logic [LANES-1:0] m_bw0;
    logic [W-1:0] g_d1 = '0;
    logic [LANES-1:0] g_bw1 = '1;

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got v=%0b d=%h expected v=%0b d=%h", req,
                     act[W], act[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                           input logic [LANES-1:0] bn);
        logic [W-1:0] r = old;
        for (int l = 0; l < LANES; l++) if (!bn[l]) r[l*9 +: 9] = d[l*9 +: 9];
        return r;
    endfunction

    task automatic edge_step(input logic rdn, input logic [AW-1:0] ra, input logic wrn,
                             input logic [AW-1:0] wa, input logic [LANES-1:0] bw,
                             input logic [W-1:0] wd);
        rd_n = rdn; rd_addr = ra; wr_n = wrn; wr_addr = wa; bw_n = bw; wdata = wd;
        if (khalf == 1'b0) begin
            if (m_wpend) begin
                mem[2*m_wa]   = merge(mem[2*m_wa], m_d0, m_bw0);
                mem[2*m_wa+1] = merge(mem[2*m_wa+1], wd, bw);
            end
            if (m_rpend) begin
                exp_v[(cyc+2)%8] = 1'b1; exp_d[(cyc+2)%8] = mem[2*m_ra];
                exp_v[(cyc+3)%8] = 1'b1; exp_d[(cyc+3)%8] = mem[2*m_ra+1];
            end
            m_rpend = !rdn; m_ra = ra; m_wpend = !wrn; m_wa = wa;
        end else if (m_wpend) begin
            m_d0 = wd; m_bw0 = bw;
        end
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, {rvalid, rdata}, {exp_v[cyc%8], exp_v[cyc%8] ? exp_d[cyc%8] : {W{1'b0}}});
        exp_v[cyc%8] = 1'b0; exp_d[cyc%8] = '0;
        cyc++;
        khalf = ~khalf;
    endtask

    // One command cycle: rising half carries commands plus the previous write's beat 1.
    task automatic kcyc(input logic rd, input logic [AW-1:0] ra, input logic wr,
                        input logic [AW-1:0] wa, input logic [LANES-1:0] bw0,
                        input logic [W-1:0] d0, input logic [LANES-1:0] bw1,
                        input logic [W-1:0] d1, input logic fall_cmd);
        logic [W-1:0] junk = W'($urandom);
        edge_step(!rd, ra, !wr, wa, g_bw1, g_d1);
        edge_step(!fall_cmd, ra + 1'b1, !fall_cmd, wa + 1'b1,
                  wr ? bw0 : '0, wr ? d0 : junk);
        g_bw1 = wr ? bw1 : '0;
        g_d1  = wr ? d1 : W'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) kcyc(0, AW'($urandom), 0, AW'($urandom), '0, '0, '0, '0, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin exp_v[i] = 0; exp_d[i] = '0; end
        for (int i = 0; i < 2*PAIRS; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0; khalf = 1'b0;
        // R1: idle outputs right after reset
        chk("R1", {rvalid, rdata}, '0);
        cur_req = "R1";
        idle(2);
        // R5: fill every pair through full-enable writes
        cur_req = "R5";
        for (int p = 0; p < PAIRS; p++)
            kcyc(0, 0, 1, AW'(p), '0, W'(p*1000 + 7), '0, W'(p*1000 + 501), 0);
        idle(2);
        // R2: isolated reads
        cur_req = "R2";
        kcyc(1, 3, 0, 0, '0, '0, '0, '0, 0); idle(2);
        kcyc(1, 15, 0, 0, '0, '0, '0, '0, 0); idle(3);
        // R9: back-to-back reads
        cur_req = "R9";
        for (int p = 0; p < 6; p++) kcyc(1, AW'(p+4), 0, 0, '0, '0, '0, '0, 0);
        idle(3);
        // R6: four beat mask combinations, per lane
        cur_req = "R6";
        kcyc(0, 0, 1, 6, 2'b00, 18'h1aaaa, 2'b11, 18'h05555, 0);
        kcyc(0, 0, 1, 7, 2'b11, 18'h12345, 2'b00, 18'h0abcd, 0);
        kcyc(0, 0, 1, 8, 2'b01, 18'h3ffff, 2'b10, 18'h2cccc, 0);
        kcyc(0, 0, 1, 9, 2'b11, 18'h3ffff, 2'b11, 18'h3ffff, 0);
        for (int p = 6; p < 10; p++) kcyc(1, AW'(p), 0, 0, '0, '0, '0, '0, 0);
        idle(3);
        // R7: deselected writes with live-looking data
        cur_req = "R7";
        kcyc(0, 0, 0, 5, 2'b00, 18'h3dead, 2'b00, 18'h3beef, 0);
        kcyc(1, 5, 0, 5, '0, '0, '0, '0, 0); idle(3);
        // R4 / R10: commands placed in the falling half
        cur_req = "R4";
        kcyc(0, 10, 0, 10, '0, '0, '0, '0, 1);
        kcyc(0, 10, 0, 10, '0, '0, '0, '0, 1);
        idle(3);
        cur_req = "R10";
        kcyc(1, 11, 0, 0, '0, '0, '0, '0, 0); idle(3);
        // R8: same-cycle read and write to one pair, partial masks
        cur_req = "R8";
        kcyc(1, 12, 1, 12, 2'b10, 18'h2f00f, 2'b01, 18'h10ff0, 0);
        kcyc(1, 12, 1, 12, 2'b00, 18'h0aa55, 2'b00, 18'h155aa, 0);
        kcyc(1, 12, 0, 0, '0, '0, '0, '0, 0);
        idle(3);
        // R3: deselected reads with moving address
        cur_req = "R3";
        for (int i = 0; i < 4; i++) kcyc(0, AW'(i), 0, 0, '0, '0, '0, '0, 0);
        idle(2);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        bad++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule